// File: doc/BRIEF.md
# I2C Addressed Transaction Sequencer

This block runs one complete register-addressed transfer with an I2C target. It does so by handing single-byte commands to a separate byte-level bus engine. A request names the following:

- a 7-bit target address;
- an internal offset of 0 to `OFF_MAX` bytes;
- an operation (write, read or probe);
- a byte count.

The sequencer builds every byte command with the right start, stop, read and not-acknowledge qualifiers. For each byte it polls the engine's flags until they show the byte has completed. Any wait that runs longer than about 10 ms counts as a failure, and the transaction is aborted.

A write sends the address byte and the offset bytes, then takes payload bytes from a valid/ready stream and sends them. A read first sends the offset as a write. It then turns the bus round with a repeated start and returns each received byte on a one-cycle valid strobe. A probe checks whether a target answers.

Every accepted request ends with exactly one `done` strobe carrying a 3-bit result code. Every failure also pulses the engine reset.

Top module: `i2c_txn_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `cmd_valid`, `wr_ready`, `rd_valid` and `eng_reset` are all low.
- R2: A write request (op 0) first issues a command with start set and data {addr, 0}. It then issues the offset bytes with no qualifier. Last come the payload bytes taken from the write stream, with stop set on the final one. Every written byte must be acknowledged.
- R3: The offset bytes go out most significant byte first, taken from the low `req_off_len` bytes of `req_offset`. An offset length of 0 issues no offset byte.
- R4: A read request (op 1) sends the address and offset as in a write, with no stop. It then issues start with data {addr, 1}. Next come read commands: every one but the last has the not-acknowledge bit clear, and the last has both not-acknowledge and stop set. Each received byte appears once on `rd_data` with `rd_valid`.
- R5: A read with length 0 ends at once with code 1. It issues no command and pulses no engine reset.
- R6: A probe (op 2) issues start with {addr, 1}, then one read command with not-acknowledge and stop set. It ends with code 0 and produces no `rd_valid`. If the address byte is refused, the result is code 3.
- R7: A write byte whose acknowledge error flag is still set after the timeout aborts the transaction with code 3. No further command is issued.
- R8: If the transmit-empty flag fails to appear within the timeout, the result is code 2. If the receive-full flag fails to appear, the result is code 4. The timeout is `CLK_HZ/100` cycles and restarts for each wait.
- R9: If the bus-busy flag stays set for the whole timeout before a byte, the result is code 6 and that byte is not issued.
- R10: Op 3, or an offset length above `OFF_MAX`, ends with code 5 and issues no command.
- R11: Each accepted request yields exactly one `done` pulse. A `req_valid` that arrives while `busy` is high is ignored.
- R12: Each command is a one-cycle `cmd_valid` pulse. After each completion flag it has consumed, the block pulses `eng_flag_clr`. Every non-zero result pulses `eng_reset` together with `done`, except code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a transaction (taken only when idle) |
| req_op | input | 2 | 0 write, 1 read, 2 probe, 3 illegal |
| req_addr | input | 7 | Target address |
| req_off_len | input | $clog2(OFF_MAX+1) | Number of offset bytes |
| req_offset | input | 8*OFF_MAX | Offset value, low bytes used |
| req_len | input | LEN_W | Payload byte count |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction strobe |
| status | output | 3 | Result code, valid with done |
| wr_data | input | 8 | Write payload byte |
| wr_valid | input | 1 | Write payload byte available |
| wr_ready | output | 1 | Sequencer takes the byte this cycle |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | Received byte strobe |
| cmd_valid | output | 1 | Byte command strobe to engine |
| cmd_data | output | 8 | Byte to transmit (0 for reads) |
| cmd_start | output | 1 | Generate (repeated) start before the byte |
| cmd_stop | output | 1 | Generate stop after the byte |
| cmd_read | output | 1 | Receive a byte instead of sending |
| cmd_nack | output | 1 | Answer received byte with not-acknowledge |
| eng_bus_busy | input | 1 | Engine reports bus busy |
| eng_tx_empty | input | 1 | Engine finished sending a byte |
| eng_rx_full | input | 1 | Engine holds a received byte |
| eng_nack | input | 1 | Target did not acknowledge |
| eng_rx_data | input | 8 | Received byte from engine |
| eng_flag_clr | output | 1 | Clear transmit-empty / receive-full flags |
| eng_reset | output | 1 | Reset the engine after an error |

## Verification
The bench builds the sequencer with `CLK_HZ` set to 10000. This shrinks every wait limit to 100 cycles, so the timeout paths for transmit, receive, acknowledge and bus-busy can each be driven to expiry and measured. `OFF_MAX` stays at 4 and `LEN_W` at 8, so the full four-byte offset ordering and multi-byte reads and writes are covered. A behavioural engine model with fixed latency answers commands, returns counting read data and injects refusals and stalls.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_READ  = 2'd1,
        OP_PROBE = 2'd2,
        OP_BAD   = 2'd3
    } seq_op_e;

    typedef enum logic [2:0] {
        CODE_OK       = 3'd0,
        CODE_EMPTY    = 3'd1,
        CODE_TX_TMO   = 3'd2,
        CODE_NO_ACK   = 3'd3,
        CODE_RX_TMO   = 3'd4,
        CODE_ILLEGAL  = 3'd5,
        CODE_BUS_BUSY = 3'd6
    } seq_code_e;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_FETCH     = 3'd1,
        ST_WAIT_FREE = 3'd2,
        ST_WAIT_DONE = 3'd3,
        ST_WAIT_ACK  = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_ADDR_WR = 2'd0,
        PH_OFFSET  = 2'd1,
        PH_ADDR_RD = 2'd2,
        PH_DATA    = 2'd3
    } seq_phase_e;

    typedef struct packed {
        logic       valid;
        logic       start;
        logic       stop;
        logic       rd;
        logic       nack;
        logic [7:0] data;
    } byte_cmd_t;

endpackage

// File: rtl/i2c_seq_timer.sv
module i2c_seq_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (restart)
            count_d = '0;
        else if (!expired)
            count_d = count_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign expired = (count_q == CNT_W'(LIMIT));
endmodule

// File: rtl/i2c_seq_cmdgen.sv
module i2c_seq_cmdgen
    import i2c_seq_pkg::*;
#(
    parameter int OFF_MAX = 4
) (
    input  seq_phase_e                      phase,
    input  logic                            is_read,
    input  logic                            last,
    input  logic [6:0]                      addr,
    input  logic [$clog2(OFF_MAX+1)-1:0]    off_cnt,
    input  logic [8*OFF_MAX-1:0]            offset,
    input  logic [7:0]                      wbyte,
    output byte_cmd_t                       cmd
);
    localparam int OFF_W = $clog2(OFF_MAX + 1);
    localparam int SEL_W = (OFF_MAX > 1) ? $clog2(OFF_MAX) : 1;

    logic [7:0]       ofs_byte [OFF_MAX];
    logic [SEL_W-1:0] sel;
    logic [OFF_W-1:0] cnt_m1;

    for (genvar g = 0; g < OFF_MAX; g++) begin : g_slice
        assign ofs_byte[g] = offset[8*g +: 8];
    end

    assign cnt_m1 = off_cnt - 1'b1;
    assign sel    = SEL_W'(cnt_m1);

    always_comb begin
        cmd       = '0;
        cmd.valid = 1'b1;
        unique case (phase)
            PH_ADDR_WR: begin
                cmd.start = 1'b1;
                cmd.data  = {addr, 1'b0};
            end
            PH_OFFSET: begin
                cmd.data  = ofs_byte[sel];
            end
            PH_ADDR_RD: begin
                cmd.start = 1'b1;
                cmd.data  = {addr, 1'b1};
            end
            default: begin
                if (is_read) begin
                    cmd.rd   = 1'b1;
                    cmd.nack = last;
                    cmd.stop = last;
                end else begin
                    cmd.data = wbyte;
                    cmd.stop = last;
                end
            end
        endcase
    end
endmodule

// File: rtl/i2c_txn_seq.sv
module i2c_txn_seq
    import i2c_seq_pkg::*;
#(
    parameter int CLK_HZ  = 100_000_000,
    parameter int LEN_W   = 8,
    parameter int OFF_MAX = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic [1:0]                    req_op,
    input  logic [6:0]                    req_addr,
    input  logic [$clog2(OFF_MAX+1)-1:0]  req_off_len,
    input  logic [8*OFF_MAX-1:0]          req_offset,
    input  logic [LEN_W-1:0]              req_len,
    output logic                          busy,
    output logic                          done,
    output logic [2:0]                    status,
    input  logic [7:0]                    wr_data,
    input  logic                          wr_valid,
    output logic                          wr_ready,
    output logic [7:0]                    rd_data,
    output logic                          rd_valid,
    output logic                          cmd_valid,
    output logic [7:0]                    cmd_data,
    output logic                          cmd_start,
    output logic                          cmd_stop,
    output logic                          cmd_read,
    output logic                          cmd_nack,
    input  logic                          eng_bus_busy,
    input  logic                          eng_tx_empty,
    input  logic                          eng_rx_full,
    input  logic                          eng_nack,
    input  logic [7:0]                    eng_rx_data,
    output logic                          eng_flag_clr,
    output logic                          eng_reset
);
    localparam int TMO_CYC  = (CLK_HZ / 100 < 1) ? 1 : CLK_HZ / 100;
    localparam int OFF_W    = $clog2(OFF_MAX + 1);
    localparam int OFS_BITS = 8 * OFF_MAX;

    typedef struct packed {
        seq_state_e            state;
        seq_phase_e            phase;
        logic                  is_read;
        logic                  is_probe;
        logic [6:0]            addr;
        logic [OFF_W-1:0]      off_cnt;
        logic [OFS_BITS-1:0]   offset;
        logic [LEN_W-1:0]      len;
        logic [7:0]            wbyte;
        byte_cmd_t             cmd;
        logic                  flag_clr;
        logic                  rd_valid;
        logic [7:0]            rd_data;
        logic                  done;
        seq_code_e             code;
        logic                  eng_rst;
    } seq_reg_t;

    seq_reg_t  seq_d, seq_q;
    byte_cmd_t next_cmd;
    logic      tmo_restart, tmo_expired;

    i2c_seq_cmdgen #(.OFF_MAX(OFF_MAX)) u_cmdgen (
        .phase   (seq_q.phase),
        .is_read (seq_q.is_read),
        .last    (seq_q.len == LEN_W'(1)),
        .addr    (seq_q.addr),
        .off_cnt (seq_q.off_cnt),
        .offset  (seq_q.offset),
        .wbyte   (seq_q.wbyte),
        .cmd     (next_cmd)
    );

    i2c_seq_timer #(.LIMIT(TMO_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmo_restart),
        .expired (tmo_expired)
    );

    function automatic seq_reg_t finish(seq_reg_t s, seq_code_e c, logic rst_eng);
        s.done    = 1'b1;
        s.code    = c;
        s.eng_rst = rst_eng;
        s.state   = ST_IDLE;
        return s;
    endfunction

    function automatic seq_reg_t to_payload(seq_reg_t s);
        if (s.is_read) begin
            s.phase = PH_ADDR_RD;
            s.state = ST_WAIT_FREE;
        end else if (s.len == '0) begin
            s = finish(s, CODE_OK, 1'b0);
        end else begin
            s.phase = PH_DATA;
            s.state = ST_FETCH;
        end
        return s;
    endfunction

    function automatic seq_reg_t advance(seq_reg_t s);
        unique case (s.phase)
            PH_ADDR_WR: begin
                if (s.off_cnt != '0) begin
                    s.phase = PH_OFFSET;
                    s.state = ST_WAIT_FREE;
                end else begin
                    s = to_payload(s);
                end
            end
            PH_OFFSET: begin
                s.off_cnt = s.off_cnt - 1'b1;
                if (s.off_cnt != '0) s.state = ST_WAIT_FREE;
                else                 s = to_payload(s);
            end
            PH_ADDR_RD: begin
                s.phase = PH_DATA;
                s.state = ST_WAIT_FREE;
            end
            default: begin
                s.len = s.len - 1'b1;
                if (s.len == '0) s = finish(s, CODE_OK, 1'b0);
                else             s.state = s.is_read ? ST_WAIT_FREE : ST_FETCH;
            end
        endcase
        return s;
    endfunction

    always_comb begin
        seq_d           = seq_q;
        seq_d.cmd.valid = 1'b0;
        seq_d.flag_clr  = 1'b0;
        seq_d.rd_valid  = 1'b0;
        seq_d.done      = 1'b0;
        seq_d.eng_rst   = 1'b0;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    seq_d.addr     = req_addr;
                    seq_d.offset   = req_offset;
                    seq_d.off_cnt  = req_off_len;
                    seq_d.len      = req_len;
                    seq_d.is_read  = (req_op == OP_READ);
                    seq_d.is_probe = 1'b0;
                    seq_d.phase    = PH_ADDR_WR;
                    if (req_op == OP_BAD || int'(req_off_len) > OFF_MAX) begin
                        seq_d = finish(seq_d, CODE_ILLEGAL, 1'b1);
                    end else if (req_op == OP_READ && req_len == '0) begin
                        seq_d = finish(seq_d, CODE_EMPTY, 1'b0);
                    end else if (req_op == OP_PROBE) begin
                        seq_d.is_read  = 1'b1;
                        seq_d.is_probe = 1'b1;
                        seq_d.len      = LEN_W'(1);
                        seq_d.off_cnt  = '0;
                        seq_d.phase    = PH_ADDR_RD;
                        seq_d.state    = ST_WAIT_FREE;
                    end else begin
                        seq_d.state    = ST_WAIT_FREE;
                    end
                end
            end
            ST_FETCH: begin
                if (wr_valid) begin
                    seq_d.wbyte = wr_data;
                    seq_d.state = ST_WAIT_FREE;
                end
            end
            ST_WAIT_FREE: begin
                if (!eng_bus_busy) begin
                    seq_d.cmd   = next_cmd;
                    seq_d.state = ST_WAIT_DONE;
                end else if (tmo_expired) begin
                    seq_d = finish(seq_d, CODE_BUS_BUSY, 1'b1);
                end
            end
            ST_WAIT_DONE: begin
                if (seq_q.cmd.rd ? eng_rx_full : eng_tx_empty) begin
                    seq_d.flag_clr = 1'b1;
                    if (seq_q.cmd.rd) begin
                        if (!seq_q.is_probe) begin
                            seq_d.rd_valid = 1'b1;
                            seq_d.rd_data  = eng_rx_data;
                        end
                        seq_d = advance(seq_d);
                    end else begin
                        seq_d.state = ST_WAIT_ACK;
                    end
                end else if (tmo_expired) begin
                    seq_d = finish(seq_d, seq_q.cmd.rd ? CODE_RX_TMO : CODE_TX_TMO, 1'b1);
                end
            end
            default: begin
                if (!eng_nack)        seq_d = advance(seq_d);
                else if (tmo_expired) seq_d = finish(seq_d, CODE_NO_ACK, 1'b1);
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign tmo_restart  = (seq_d.state != seq_q.state);
    assign busy         = (seq_q.state != ST_IDLE);
    assign done         = seq_q.done;
    assign status       = seq_q.code;
    assign wr_ready     = (seq_q.state == ST_FETCH);
    assign rd_data      = seq_q.rd_data;
    assign rd_valid     = seq_q.rd_valid;
    assign cmd_valid    = seq_q.cmd.valid;
    assign cmd_data     = seq_q.cmd.data;
    assign cmd_start    = seq_q.cmd.start;
    assign cmd_stop     = seq_q.cmd.stop;
    assign cmd_read     = seq_q.cmd.rd;
    assign cmd_nack     = seq_q.cmd.nack;
    assign eng_flag_clr = seq_q.flag_clr;
    assign eng_reset    = seq_q.eng_rst;
endmodule

// File: rtl/i2c_seq_checker.sv
module i2c_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic [2:0] status,
    input logic       wr_ready,
    input logic       rd_valid,
    input logic       cmd_valid,
    input logic       cmd_start,
    input logic       cmd_stop,
    input logic       cmd_read,
    input logic       cmd_nack,
    input logic       eng_reset
);
    // R12: a command lasts exactly one cycle
    assert_cmd_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R11: commands only inside a transaction
    assert_cmd_in_txn_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> busy);

    // R11: completion strobe leaves the block idle
    assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7: engine reset only on an error completion
    assert_reset_on_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_reset |-> (done && status != 3'd0));

    // R5: empty read does not reset the engine
    assert_empty_no_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == 3'd1) |-> !eng_reset);

    // R2: stop only on payload bytes, never with start
    assert_stop_not_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_stop) |-> !cmd_start);

    // R4: not-acknowledge only on the final read byte
    assert_nack_last_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_nack) |-> (cmd_read && cmd_stop));

    // R4: read data follows a read command
    assert_rd_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> cmd_read);

    // R12: write stream never accepted while a command is outstanding
    assert_ready_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> !cmd_valid);
endmodule

bind i2c_txn_seq i2c_seq_checker u_seq_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .status    (status),
    .wr_ready  (wr_ready),
    .rd_valid  (rd_valid),
    .cmd_valid (cmd_valid),
    .cmd_start (cmd_start),
    .cmd_stop  (cmd_stop),
    .cmd_read  (cmd_read),
    .cmd_nack  (cmd_nack),
    .eng_reset (eng_reset)
);

// File: tb/test_i2c_txn_seq.sv
`timescale 1ns/1ps
module test_i2c_txn_seq;
    localparam int CLK_HZ_TB = 10000;
    localparam int TMO       = CLK_HZ_TB / 100;
    localparam int LEN_W     = 8;
    localparam int OFF_MAX   = 4;
    localparam int ENG_LAT   = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = '0;
    logic [6:0]  req_addr = '0;
    logic [2:0]  req_off_len = '0;
    logic [31:0] req_offset = '0;
    logic [7:0]  req_len = '0;
    logic        busy, done, wr_ready, rd_valid;
    logic [2:0]  status;
    logic [7:0]  wr_data = '0;
    logic        wr_valid = 1'b0;
    logic [7:0]  rd_data, cmd_data;
    logic        cmd_valid, cmd_start, cmd_stop, cmd_read, cmd_nack;
    logic        eng_bus_busy;
    logic        eng_tx_empty = 1'b0, eng_rx_full = 1'b0, eng_nack = 1'b0;
    logic [7:0]  eng_rx_data = '0;
    logic        eng_flag_clr, eng_reset;

    always #4 clk = ~clk;

    i2c_txn_seq #(.CLK_HZ(CLK_HZ_TB), .LEN_W(LEN_W), .OFF_MAX(OFF_MAX)) i_i2c_txn_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_off_len(req_off_len), .req_offset(req_offset),
        .req_len(req_len), .busy(busy), .done(done), .status(status),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .cmd_valid(cmd_valid),
        .cmd_data(cmd_data), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .cmd_read(cmd_read), .cmd_nack(cmd_nack), .eng_bus_busy(eng_bus_busy),
        .eng_tx_empty(eng_tx_empty), .eng_rx_full(eng_rx_full), .eng_nack(eng_nack),
        .eng_rx_data(eng_rx_data), .eng_flag_clr(eng_flag_clr), .eng_reset(eng_reset)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    int done_cnt = 0, rst_cnt = 0, last_code = 0;
    logic [11:0] exp_q[$];
    logic [7:0]  wq[$];
    logic [7:0]  rd_q[$];
    bit stall_tx = 0, stall_rx = 0, busy_force = 0;
    int nack_idx = -1;
    string cur_req = "R1";

    assign eng_bus_busy = busy_force;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [11:0] pk(bit s, bit p, bit r, bit n, logic [7:0] d);
        return {s, p, r, n, d};
    endfunction

    // behavioural byte engine and per-clock command comparison
    int pend = 0, widx = 0, ridx = 0;
    bit pend_rd = 0, pend_nack = 0;
    always @(posedge clk) begin
        if (rst_n) begin
            if (req_valid && !busy) begin widx = 0; ridx = 0; end
            if (eng_flag_clr) begin eng_tx_empty <= 1'b0; eng_rx_full <= 1'b0; end
            if (eng_reset) begin
                eng_tx_empty <= 1'b0; eng_rx_full <= 1'b0; eng_nack <= 1'b0; pend = 0;
            end
            if (cmd_valid) begin
                logic [11:0] got;
                got = {cmd_start, cmd_stop, cmd_read, cmd_nack, cmd_data};
                if (exp_q.size() == 0) begin
                    check(0, cur_req, "unexpected command", got, 0);
                end else begin
                    logic [11:0] e;
                    e = exp_q.pop_front();
                    check(got == e, cur_req, "command {start,stop,rd,nack,data}", got, e);
                end
                pend = ENG_LAT; pend_rd = cmd_read;
                pend_nack = !cmd_read && (widx == nack_idx);
                if (!cmd_read) widx++;
            end else if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    if (pend_rd) begin
                        if (!stall_rx) begin
                            eng_rx_full <= 1'b1;
                            eng_rx_data <= 8'hA0 + 8'(ridx);
                            ridx++;
                        end
                    end else if (!stall_tx) begin
                        eng_tx_empty <= 1'b1;
                        if (pend_nack) eng_nack <= 1'b1;
                    end
                end
            end
        end
    end

    always @(posedge clk) begin
        if (done) begin done_cnt++; last_code = int'(status); end
        if (eng_reset) rst_cnt++;
        if (rd_valid) rd_q.push_back(rd_data);
        if (wr_valid && wr_ready) void'(wq.pop_front());
    end

    always @(negedge clk) begin
        wr_valid = (wq.size() > 0);
        wr_data  = wr_valid ? wq[0] : 8'h00;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic run(input logic [1:0] op, input logic [6:0] a, input logic [2:0] ol,
                       input logic [31:0] ofs, input logic [7:0] len,
                       input int exp_code, input string req, output int elapsed);
        int d0, t0, t;
        cur_req = req;
        d0 = done_cnt;
        @(negedge clk);
        req_op = op; req_addr = a; req_off_len = ol; req_offset = ofs; req_len = len;
        req_valid = 1'b1; t0 = cyc;
        @(negedge clk);
        req_valid = 1'b0;
        t = 0;
        while (done_cnt == d0 && t < 5000) begin @(negedge clk); t++; end
        elapsed = cyc - t0;
        repeat (6) @(negedge clk);
        check(done_cnt - d0 == 1, req, "done pulse count", done_cnt - d0, 1);
        check(last_code == exp_code, req, "result code", last_code, exp_code);
        check(exp_q.size() == 0, req, "missing commands", exp_q.size(), 0);
        exp_q.delete(); wq.delete();
    endtask

    initial begin
        int el, r0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy && !done && !cmd_valid && !wr_ready && !rd_valid && !eng_reset,
              "R1", "idle outputs", {busy, done, cmd_valid, wr_ready, rd_valid, eng_reset}, 0);

        // R2 R3 write with 2-byte offset, MSB first
        exp_q = '{pk(1,0,0,0,8'hA0), pk(0,0,0,0,8'h12), pk(0,0,0,0,8'h34),
                  pk(0,0,0,0,8'h11), pk(0,0,0,0,8'h22), pk(0,1,0,0,8'h33)};
        wq = '{8'h11, 8'h22, 8'h33};
        run(2'd0, 7'h50, 3'd2, 32'h1234, 8'd3, 0, "R2", el);

        // R3 no offset bytes
        exp_q = '{pk(1,0,0,0,8'h78), pk(0,1,0,0,8'h5A)};
        wq = '{8'h5A};
        run(2'd0, 7'h3C, 3'd0, 32'hFFFF_FFFF, 8'd1, 0, "R3", el);

        // R4 read, 3 bytes
        rd_q.delete();
        exp_q = '{pk(1,0,0,0,8'h34), pk(0,0,0,0,8'h07), pk(1,0,0,0,8'h35),
                  pk(0,0,1,0,8'h00), pk(0,0,1,0,8'h00), pk(0,1,1,1,8'h00)};
        run(2'd1, 7'h1A, 3'd1, 32'h07, 8'd3, 0, "R4", el);
        check(rd_q.size() == 3, "R4", "read byte count", rd_q.size(), 3);
        for (int i = 0; i < 3 && i < rd_q.size(); i++)
            check(rd_q[i] == 8'hA0 + 8'(i), "R4", "read byte", rd_q[i], 8'hA0 + i);

        // R3 R4 four-byte offset, single byte read
        rd_q.delete();
        exp_q = '{pk(1,0,0,0,8'hFE), pk(0,0,0,0,8'hDE), pk(0,0,0,0,8'hAD),
                  pk(0,0,0,0,8'hBE), pk(0,0,0,0,8'hEF), pk(1,0,0,0,8'hFF),
                  pk(0,1,1,1,8'h00)};
        run(2'd1, 7'h7F, 3'd4, 32'hDEAD_BEEF, 8'd1, 0, "R3", el);
        check(rd_q.size() == 1 && rd_q[0] == 8'hA0, "R4", "single read byte",
              rd_q.size() > 0 ? rd_q[0] : 0, 8'hA0);

        // R5 empty read
        r0 = rst_cnt;
        run(2'd1, 7'h22, 3'd1, 32'h0, 8'd0, 1, "R5", el);
        check(rst_cnt == r0, "R5", "engine reset count", rst_cnt - r0, 0);

        // R6 probe present
        rd_q.delete();
        exp_q = '{pk(1,0,0,0,8'h41), pk(0,1,1,1,8'h00)};
        run(2'd2, 7'h20, 3'd3, 32'h55, 8'd9, 0, "R6", el);
        check(rd_q.size() == 0, "R6", "probe read strobes", rd_q.size(), 0);

        // R6 R7 probe absent
        r0 = rst_cnt; nack_idx = 0;
        exp_q = '{pk(1,0,0,0,8'h43)};
        run(2'd2, 7'h21, 3'd0, 32'h0, 8'd1, 3, "R6", el);
        check(rst_cnt - r0 == 1, "R7", "engine reset on refusal", rst_cnt - r0, 1);

        // R7 refusal on second offset byte aborts
        nack_idx = 2;
        exp_q = '{pk(1,0,0,0,8'hA0), pk(0,0,0,0,8'hAB), pk(0,0,0,0,8'hCD)};
        wq = '{8'h01, 8'h02};
        run(2'd0, 7'h50, 3'd2, 32'hABCD, 8'd2, 3, "R7", el);
        nack_idx = -1;

        // R8 transmit timeout
        stall_tx = 1;
        exp_q = '{pk(1,0,0,0,8'h20)};
        wq = '{8'h99};
        run(2'd0, 7'h10, 3'd0, 32'h0, 8'd1, 2, "R8", el);
        check(el >= TMO, "R8", "transmit timeout duration", el, TMO);
        stall_tx = 0;

        // R8 receive timeout
        stall_rx = 1;
        exp_q = '{pk(1,0,0,0,8'h22), pk(1,0,0,0,8'h23), pk(0,0,1,0,8'h00)};
        run(2'd1, 7'h11, 3'd0, 32'h0, 8'd2, 4, "R8", el);
        check(el >= TMO, "R8", "receive timeout duration", el, TMO);
        stall_rx = 0;

        // R9 bus busy
        busy_force = 1; r0 = rst_cnt;
        run(2'd0, 7'h12, 3'd1, 32'h3, 8'd1, 6, "R9", el);
        check(el >= TMO, "R9", "busy wait duration", el, TMO);
        check(rst_cnt - r0 == 1, "R12", "engine reset on busy", rst_cnt - r0, 1);
        busy_force = 0;

        // R10 illegal op and oversized offset
        r0 = rst_cnt;
        run(2'd3, 7'h12, 3'd1, 32'h3, 8'd1, 5, "R10", el);
        check(rst_cnt - r0 == 1, "R10", "engine reset on illegal op", rst_cnt - r0, 1);
        run(2'd0, 7'h12, 3'd5, 32'h3, 8'd1, 5, "R10", el);

        // R11 request while busy is ignored
        exp_q = '{pk(1,0,0,0,8'h60), pk(0,0,0,0,8'h44), pk(0,1,0,0,8'h45)};
        wq = '{8'h44, 8'h45};
        begin
            int d0, t;
            cur_req = "R11";
            d0 = done_cnt;
            @(negedge clk);
            req_op = 2'd0; req_addr = 7'h30; req_off_len = 3'd0; req_len = 8'd2;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            repeat (5) @(negedge clk);
            req_op = 2'd1; req_addr = 7'h05; req_off_len = 3'd1; req_len = 8'd1;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            t = 0;
            while (done_cnt == d0 && t < 5000) begin @(negedge clk); t++; end
            repeat (40) @(negedge clk);
            check(done_cnt - d0 == 1, "R11", "done pulses", done_cnt - d0, 1);
            check(last_code == 0, "R11", "result code", last_code, 0);
            check(exp_q.size() == 0, "R11", "missing commands", exp_q.size(), 0);
            check(!busy, "R11", "idle after ignored request", busy, 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule